// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block collects up to sixteen external input lines and turns each into a level-sensitive interrupt source. A 32-bit register port with address, write enable, write data and read data programs it. Each line first passes through a two-flop synchroniser. Software reads the synchronised levels through a data register, which is gated by a validity mask.

Detection is armed. Software writes a one to a channel's bit in the arm register, and the channel then starts measuring. It records a pending event only when the synchronised input stays at the programmed active level for the programmed number of millisecond ticks. The tick comes from an internal prescaler. A pending event is readable as raw status. It is gated by a per-channel enable into masked status, and it drives one combined interrupt line until software clears it with a write-one-to-clear.

Only levels are detected. To react to edges, software flips the channel's polarity after each event and arms the channel again.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is low.
- R2: Offset 0x00 reads the synchronised input levels ANDed with the validity mask at offset 0x04. The mask is read/write in bits 15:0.
- R3: Polarity register at 0x14: bit n = 1 makes channel n active while its input is high, and bit n = 0 makes it active while its input is low.
- R4: Writing 1 to bit n of 0x28 arms channel n. Bit n of raw status (0x1C) becomes 1 only after the input stays at the active level for the number of millisecond ticks in bits 11:0 of the channel's control register at 0x40 + 4*n.
- R5: If an armed channel's input leaves the active level before the count completes, the measurement is abandoned and no status is recorded until the channel is armed again.
- R6: A debounce value of 0 sets raw status one clock after the arming write, provided the synchronised input is already active.
- R7: Masked status (0x20) equals raw status ANDed with the enable register (0x18). `irq_out` is high exactly while any masked bit is 1.
- R8: Writing 1 to bit n of 0x24 clears raw status bit n. Writing 0 leaves it unchanged.
- R9: The arm and clear registers read 0. Raw and masked status ignore writes. Unused addresses and reserved bits read 0. Control registers keep only bits 11:0.
- R10: A channel that has not been armed never sets its status, however long its input stays active.
- R11: A change on an input pin appears in the data register two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous external input lines |
| irq_out | output | 1 | Combined interrupt, high while any masked status bit is set |

## Verification
The hardest case to reach is an abandoned measurement. The input has to leave the active level after the arm but before the tick count completes, and then return. The bench arms a channel with a three-tick debounce, releases the pin partway through the count, and drives it back active for several times the debounce window. It then confirms that raw status stays clear until a fresh arm write. The bench shrinks the prescaler to ten clocks per tick so that tick boundaries are reached in tens of cycles, and it samples status well clear of those boundaries.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int CH_MAX    = 16;

    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_VMASK = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_POL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_ARM   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h40;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
        return OFS_CFG + ADDR_W'(idx * 4);
    endfunction
endpackage

// File: rtl/lvl_irq_tick.sv
module lvl_irq_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_tick_chk
            // R4
            tick_single_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign q_sync = stab_q;

    // R11
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(meta_q) == stab_q);
endmodule

// File: rtl/lvl_irq_chan.sv
module lvl_irq_chan
    import lvl_irq_pkg::*;
#(
    parameter int DBNC_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              arm,
    input  logic              clr,
    input  logic              lvl,
    input  logic              pol,
    input  logic [DBNC_W-1:0] dbnc,
    output logic              raw,
    output logic              busy
);
    ch_state_e         st_q;
    logic [DBNC_W-1:0] cnt_q;
    logic              raw_q;
    logic              active;
    logic              hit;

    assign active = (lvl == pol);
    assign hit    = (st_q == CH_RUN) && !arm && active && (cnt_q >= dbnc);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else if (arm) begin
            st_q  <= CH_RUN;
            cnt_q <= '0;
        end else if (st_q == CH_RUN) begin
            if (!active || hit) begin
                st_q  <= CH_IDLE;
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
        end else if (hit) begin
            raw_q <= 1'b1;
        end else if (clr) begin
            raw_q <= 1'b0;
        end
    end

    assign raw  = raw_q;
    assign busy = (st_q == CH_RUN);

    // R5
    drop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !arm && !active) |=> !busy);

    // R10
    latch_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> $past(busy));

    // R8
    clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(raw) |-> $past(clr));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(arm)) |->
            ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int CLK_PER_MS = 50000,
    parameter int DBNC_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NCH-1:0]    pin_in,
    output logic              irq_out
);
    logic [NCH-1:0]    lvl_s;
    logic              tick;
    logic [NCH-1:0]    pol_q, ien_q, vmask_q;
    logic [DBNC_W-1:0] cfg_q [NCH];
    logic [NCH-1:0]    raw_v, busy_v, arm_p, clr_p, msk_v;

    lvl_irq_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(lvl_s)
    );

    lvl_irq_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    assign arm_p = (bus_we && bus_addr == OFS_ARM) ? bus_wdata[NCH-1:0] : '0;
    assign clr_p = (bus_we && bus_addr == OFS_CLR) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q   <= '0;
            ien_q   <= '0;
            vmask_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_POL)   pol_q   <= bus_wdata[NCH-1:0];
            if (bus_addr == OFS_IEN)   ien_q   <= bus_wdata[NCH-1:0];
            if (bus_addr == OFS_VMASK) vmask_q <= bus_wdata[NCH-1:0];
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[g] <= '0;
                end else if (bus_we && bus_addr == cfg_addr(g)) begin
                    cfg_q[g] <= bus_wdata[DBNC_W-1:0];
                end
            end

            lvl_irq_chan #(.DBNC_W(DBNC_W)) u_chan (
                .clk(clk), .rst(rst), .tick(tick),
                .arm(arm_p[g]), .clr(clr_p[g]),
                .lvl(lvl_s[g]), .pol(pol_q[g]), .dbnc(cfg_q[g]),
                .raw(raw_v[g]), .busy(busy_v[g])
            );
        end
    endgenerate

    assign msk_v   = raw_v & ien_q;
    assign irq_out = |msk_v;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LEVEL: bus_rdata = BUS_W'(lvl_s & vmask_q);
            OFS_VMASK: bus_rdata = BUS_W'(vmask_q);
            OFS_POL:   bus_rdata = BUS_W'(pol_q);
            OFS_IEN:   bus_rdata = BUS_W'(ien_q);
            OFS_RAW:   bus_rdata = BUS_W'(raw_v);
            OFS_MSK:   bus_rdata = BUS_W'(msk_v);
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (bus_addr == cfg_addr(n)) bus_rdata = BUS_W'(cfg_q[n]);
                end
            end
        endcase
    end

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (|ien_q));

    // R10
    no_status_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(raw_v[0])) |-> $past(busy_v[0]));
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb_top;
    import lvl_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic        irq_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lvl_irq_ctrl #(.NCH(16), .CLK_PER_MS(10), .DBNC_W(12)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{8'h14, 32'hFFFF0001, 32'h00000001},
        '{8'h18, 32'h0000FFFF, 32'h0000FFFF},
        '{8'h04, 32'h12345678, 32'h00005678},
        '{8'h40, 32'hFFFFF123, 32'h00000123},
        '{8'h7C, 32'h00000ABC, 32'h00000ABC},
        '{8'h28, 32'h00000000, 32'h00000000},
        '{8'h24, 32'h0000FFFF, 32'h00000000},
        '{8'h08, 32'hFFFFFFFF, 32'h00000000},
        '{8'h1C, 32'h0000FFFF, 32'h00000000},
        '{8'h14, 32'h00000000, 32'h00000000},
        '{8'h18, 32'h00000000, 32'h00000000},
        '{8'h7C, 32'h00000000, 32'h00000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(OFS_POL, v);  check("R1 pol", v, 0);
        rd(OFS_RAW, v);  check("R1 raw", v, 0);
        rd(OFS_CFG, v);  check("R1 cfg0", v, 0);
        check("R1 irq", 32'(irq_out), 0);

        // R9 table of register write/read vectors
        for (int i = 0; i < 12; i++) begin
            wr(VECS[i].a, VECS[i].w);
            rd(VECS[i].a, v);
            check($sformatf("R9 vec%0d", i), v, VECS[i].e);
        end

        // R2 / R11 data path and synchroniser delay
        wr(OFS_VMASK, 32'hFFFF);
        pin_in = 16'h00A5;
        @(negedge clk);
        rd(OFS_LEVEL, v); check("R11 one edge", v, 32'h0);
        @(negedge clk);
        rd(OFS_LEVEL, v); check("R11 two edges", v, 32'h00A5);
        wr(OFS_VMASK, 32'h000F);
        rd(OFS_LEVEL, v); check("R2 masked data", v, 32'h0005);
        pin_in = 16'h0000;
        wr(OFS_VMASK, 32'hFFFF);
        idle(3);

        // R10 active level without arm
        wr(OFS_POL, 32'h000B);
        pin_in = 16'h0001;
        idle(50);
        rd(OFS_RAW, v); check("R10 no arm", v, 0);

        // R6 zero debounce
        wr(OFS_CFG, 32'h0);
        wr(OFS_IEN, 32'h0001);
        wr(OFS_ARM, 32'h0001);
        rd(OFS_RAW, v); check("R6 not yet", v, 0);
        @(negedge clk);
        rd(OFS_RAW, v); check("R6 latched", v, 32'h0001);
        rd(OFS_MSK, v); check("R7 masked", v, 32'h0001);
        check("R7 irq high", 32'(irq_out), 1);

        // R8 write-one-to-clear
        wr(OFS_CLR, 32'h0000);
        rd(OFS_RAW, v); check("R8 zero write", v, 32'h0001);
        wr(OFS_CLR, 32'h0001);
        rd(OFS_RAW, v); check("R8 cleared", v, 0);
        check("R7 irq low", 32'(irq_out), 0);

        // R4 debounce count of 3 ticks, channel 1 active high
        wr(cfg_addr(1), 32'd3);
        pin_in = 16'h0003;
        idle(3);
        wr(OFS_ARM, 32'h0002);
        idle(15);
        rd(OFS_RAW, v); check("R4 too early", v, 0);
        idle(25);
        rd(OFS_RAW, v); check("R4 expired", v, 32'h0002);
        rd(OFS_MSK, v); check("R7 disabled ch", v, 0);
        check("R7 irq off", 32'(irq_out), 0);

        // R5 / R3 abandoned count, channel 2 active low
        wr(cfg_addr(2), 32'd3);
        wr(OFS_ARM, 32'h0004);
        idle(12);
        pin_in = 16'h0007;
        idle(60);
        pin_in = 16'h0003;
        idle(60);
        rd(OFS_RAW, v); check("R5 abandoned", v, 32'h0002);
        wr(OFS_ARM, 32'h0004);
        idle(45);
        rd(OFS_RAW, v); check("R3 active low", v, 32'h0006);

        // R3 inactive level on active-high channel 3
        wr(OFS_ARM, 32'h0008);
        idle(10);
        rd(OFS_RAW, v); check("R3 inactive", v, 32'h0006);

        // R9 arm/clear read back 0
        rd(OFS_ARM, v); check("R9 arm reads 0", v, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule